// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the shared front end of a small multi-core interrupt controller. It holds, for every interrupt ID, an enable bit, a pending bit, an 8-bit priority, an 8-bit core-routing mask and a 2-bit trigger setting. It raises a per-core request line whenever some interrupt that is enabled, pending and routed to that core exists while the global switch is on. Software reaches all of this state through a simple 32-bit word-addressed register bus. Every access carries the number of the core that issues it.

IDs 0 to 31 are private. Each core has its own enable and pending copy for them, and its own accesses reach only that copy. IDs 0 to 15 are made pending by a software-trigger register that can target several cores at once. IDs 16 to 31 come from per-core level lines. IDs 32 and up are shared and come from external source lines that are level- or edge-sensitive, as configured. The defaults are 2 cores and 64 IDs.

Top module: `irq_dist_regs`

## Requirements
- R1: After synchronous reset, the global switch, all enables, all pending bits, the shared routing masks and the trigger settings are 0, and `core_irq` and `rd_data` are 0.
- R2: The enable-set words are at word address 0x040+w and the enable-clear words at 0x060+w. Writing a 1 bit to a set word enables that interrupt, and writing a 1 bit to a clear word disables it. Zero bits leave the state unchanged. Reading either word returns the current enables.
- R3: Interrupt N sits at bit N mod 32 of enable and pending word N/32.
- R4: The priority of interrupt N is byte N mod 4 (bits 8*(N mod 4)+7:8*(N mod 4)) of word 0x100+N/4. The field is read/write and keeps the last value written.
- R5: The routing mask of shared interrupt N is byte N mod 4 of word 0x200+N/4, and bit k sends it to core k. The routing words of private IDs (0x200 to 0x207) read as 0x01 shifted left by the requesting core in every byte, and writes to them are ignored.
- R6: The trigger settings are 2 bits per ID, 16 IDs per word, at word 0x300+N/16, bits 2*(N mod 16)+1:2*(N mod 16). They are read/write. For shared IDs, a 1 in the upper bit of the pair makes the pending bit set on a rising edge of the source line. With the upper bit at 0, the pending bit is set in every cycle the line is high.
- R7: Word 0x001 is read-only and reads NUM_IRQ/32-1 in bits 4:0 and NUM_CORES-1 in bits 7:5. This is 0x21 by default. Writes to it are ignored.
- R8: Enable and pending accesses to word 0 reach only the copy of the requesting core (`bus_core`).
- R9: Bit 0 of word 0x000 is the global switch. While it is 0, `core_irq` stays 0 in the following cycle.
- R10: A write to word 0x0C0 sets interrupt ID bits 3:0 pending on each core k whose bit 16+k is 1.
- R11: Words beyond the implemented IDs (enable word 2 and up, priority and routing word 16 and up, trigger word 4 and up) and unmapped addresses read 0, and writes to them change nothing.
- R12: `core_irq[k]` is a register. It is 1 in the cycle after a cycle in which the switch is on and some interrupt is enabled, pending and routed to core k. Private IDs route only to their own core.
- R13: Writing a 1 bit to pending-clear word 0xA0+w clears that pending bit, except that a level-triggered source still high sets it again. Reading the word returns the pending bits.
- R14: `rd_data` shows the addressed word in the cycle after a read request and is 0 in the cycle after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_core | input | CORE_W | Core issuing the access |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| spi_in | input | NUM_IRQ-32 | Shared source lines, bit j is ID 32+j |
| ppi_in | input | NUM_CORES*16 | Private level lines, bit 16*c+i is ID 16+i of core c |
| core_irq | output | NUM_CORES | Per-core request |

## Verification
The hardest case to reach is a pending-clear write that arrives while a source line is still high. For a level-triggered ID the bit must come back at once. For an edge-triggered ID it must stay cleared. The bench holds a line high across the clear in both trigger settings and watches `core_irq` in the cycle after the write. The second difficult area is the banked private state. The bench gives the two cores different enable and software-trigger patterns and then reads each copy back through the other core's view, which shows whether an access reached only its own core's copy.

// File: rtl/irq_dist_pkg.sv
`timescale 1ns/1ps
package irq_dist_pkg;
  localparam int ADDR_W = 10;
  localparam int SGI_TGT_LSB = 16;

  typedef enum logic [1:0] {
    RG_MISC = 2'd0,
    RG_PRIO = 2'd1,
    RG_TGT  = 2'd2,
    RG_CFG  = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    SUB_CTL   = 3'd0,
    SUB_ENSET = 3'd2,
    SUB_ENCLR = 3'd3,
    SUB_PCLR  = 3'd5,
    SUB_SGI   = 3'd6
  } misc_e;
endpackage

// File: rtl/irq_dist_prio_ram.sv
`timescale 1ns/1ps
module irq_dist_prio_ram #(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/irq_dist_core_bank.sv
`timescale 1ns/1ps
module irq_dist_core_bank (
  input  logic        clk,
  input  logic        rst,
  input  logic        set_we,
  input  logic        clr_we,
  input  logic        pclr_we,
  input  logic [31:0] wdata,
  input  logic [15:0] sgi_mask,
  input  logic [15:0] ppi_in,
  output logic [31:0] en_q,
  output logic [31:0] pd_q
);
  logic [31:0] set_m, clr_m, pclr_m, src_m;

  always_comb begin
    set_m  = set_we  ? wdata : '0;
    clr_m  = clr_we  ? wdata : '0;
    pclr_m = pclr_we ? wdata : '0;
    src_m  = {ppi_in, sgi_mask};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      pd_q <= '0;
    end else begin
      en_q <= (en_q | set_m) & ~clr_m;
      pd_q <= (pd_q & ~pclr_m) | src_m;
    end
  end
endmodule

// File: rtl/irq_dist_route.sv
`timescale 1ns/1ps
module irq_dist_route #(
  parameter int NUM_CORES = 2,
  parameter int NUM_IRQ   = 64,
  localparam int NS = NUM_IRQ - 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    gen,
  input  logic [NUM_CORES*32-1:0] priv_en,
  input  logic [NUM_CORES*32-1:0] priv_pd,
  input  logic [NS-1:0]           sh_en,
  input  logic [NS-1:0]           sh_pd,
  input  logic [NS*8-1:0]         sh_tgt,
  output logic [NUM_CORES-1:0]    core_irq
);
  logic [NUM_CORES-1:0] hit;

  always_comb begin
    for (int k = 0; k < NUM_CORES; k++) begin
      logic [NS-1:0] tbit;
      for (int j = 0; j < NS; j++) tbit[j] = sh_tgt[j*8+k];
      hit[k] = (|(priv_en[k*32 +: 32] & priv_pd[k*32 +: 32]))
             | (|(sh_en & sh_pd & tbit));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) core_irq <= '0;
    else     core_irq <= gen ? hit : '0;
  end
endmodule

// File: rtl/irq_dist_regs.sv
`timescale 1ns/1ps
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int NUM_IRQ   = 64,
  localparam int CORE_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    bus_req,
  input  logic                    bus_wr,
  input  logic [CORE_W-1:0]       bus_core,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             rd_data,
  input  logic [NUM_IRQ-33:0]     spi_in,
  input  logic [NUM_CORES*16-1:0] ppi_in,
  output logic [NUM_CORES-1:0]    core_irq
);
  localparam int NS   = NUM_IRQ - 32;
  localparam int NW32 = NUM_IRQ / 32;
  localparam int NW4  = NUM_IRQ / 4;
  localparam int NW16 = NUM_IRQ / 16;
  localparam int PAW  = (NW4 > 1) ? $clog2(NW4) : 1;
  localparam int CFW  = (NW16 > 1) ? $clog2(NW16) : 1;
  localparam logic [31:0] TYPE_VAL =
    32'((NUM_IRQ / 32 - 1) & 31) | (32'((NUM_CORES - 1) & 7) << 5);

  // Decode
  logic [1:0] region;
  logic [2:0] sub;
  logic [4:0] widx;
  logic [7:0] bidx;
  logic is_wr, is_rd, misc, core_ok;
  logic ctl_hit, type_hit, ens_hit, enc_hit, pcl_hit, sgi_hit, prio_hit;

  always_comb begin
    region   = bus_addr[9:8];
    sub      = bus_addr[7:5];
    widx     = bus_addr[4:0];
    bidx     = bus_addr[7:0];
    is_wr    = bus_req & bus_wr;
    is_rd    = bus_req & ~bus_wr;
    misc     = (region == RG_MISC);
    core_ok  = int'(bus_core) < NUM_CORES;
    ctl_hit  = misc && sub == SUB_CTL && widx == 5'd0;
    type_hit = misc && sub == SUB_CTL && widx == 5'd1;
    ens_hit  = misc && sub == SUB_ENSET;
    enc_hit  = misc && sub == SUB_ENCLR;
    pcl_hit  = misc && sub == SUB_PCLR;
    sgi_hit  = misc && sub == SUB_SGI && widx == 5'd0;
    prio_hit = (region == RG_PRIO) && int'(bidx) < NW4;
  end

  // Global switch
  logic gen_q;
  always_ff @(posedge clk) begin
    if (rst)                     gen_q <= 1'b0;
    else if (is_wr && ctl_hit)   gen_q <= bus_wdata[0];
  end

  // Trigger settings
  logic [31:0] cfg_q [NW16];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NW16; i++) cfg_q[i] <= '0;
    end else if (is_wr && region == RG_CFG && int'(bidx) < NW16) begin
      cfg_q[bidx[CFW-1:0]] <= bus_wdata;
    end
  end

  // Shared enable / pending
  logic [NS-1:0] en_sh, pd_sh, spi_q;
  logic [NS-1:0] ens_m, enc_m, pcl_m, src_hit;

  always_comb begin
    ens_m = '0;
    enc_m = '0;
    pcl_m = '0;
    for (int w = 1; w < NW32; w++) begin
      if (is_wr && int'(widx) == w) begin
        if (ens_hit) ens_m[(w-1)*32 +: 32] = bus_wdata;
        if (enc_hit) enc_m[(w-1)*32 +: 32] = bus_wdata;
        if (pcl_hit) pcl_m[(w-1)*32 +: 32] = bus_wdata;
      end
    end
    for (int j = 0; j < NS; j++) begin
      if (cfg_q[(j+32)/16][2*((j+32)%16)+1])
        src_hit[j] = spi_in[j] & ~spi_q[j];
      else
        src_hit[j] = spi_in[j];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_sh <= '0;
      pd_sh <= '0;
      spi_q <= '0;
    end else begin
      en_sh <= (en_sh | ens_m) & ~enc_m;
      pd_sh <= (pd_sh & ~pcl_m) | src_hit;
      spi_q <= spi_in;
    end
  end

  // Shared routing masks
  logic [7:0]      tgt_sh [NS];
  logic [NS*8-1:0] tgt_flat;
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int j = 0; j < NS; j++) tgt_sh[j] <= '0;
    end else if (is_wr && region == RG_TGT) begin
      for (int j = 0; j < NS; j++)
        if (int'(bidx) == (j + 32) / 4) tgt_sh[j] <= bus_wdata[8*(j%4) +: 8];
    end
  end

  // Private banks
  logic [31:0] bank_en [NUM_CORES];
  logic [31:0] bank_pd [NUM_CORES];
  logic [NUM_CORES*32-1:0] priv_en_f, priv_pd_f;
  logic [15:0] sgi_onehot;
  assign sgi_onehot = 16'd1 << bus_wdata[3:0];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_bank
    logic mine, sgi_me;
    assign mine   = core_ok && int'(bus_core) == c && widx == 5'd0;
    assign sgi_me = is_wr && sgi_hit && bus_wdata[SGI_TGT_LSB + c];
    irq_dist_core_bank u_bank (
      .clk      (clk),
      .rst      (rst),
      .set_we   (is_wr && ens_hit && mine),
      .clr_we   (is_wr && enc_hit && mine),
      .pclr_we  (is_wr && pcl_hit && mine),
      .wdata    (bus_wdata),
      .sgi_mask (sgi_me ? sgi_onehot : 16'd0),
      .ppi_in   (ppi_in[c*16 +: 16]),
      .en_q     (bank_en[c]),
      .pd_q     (bank_pd[c])
    );
    assign priv_en_f[c*32 +: 32] = bank_en[c];
    assign priv_pd_f[c*32 +: 32] = bank_pd[c];
  end

  for (genvar j = 0; j < NS; j++) begin : g_tflat
    assign tgt_flat[j*8 +: 8] = tgt_sh[j];
  end

  // Priority storage
  logic [31:0] prio_q;
  irq_dist_prio_ram #(.DEPTH(NW4)) u_prio (
    .clk   (clk),
    .we    (is_wr && prio_hit),
    .re    (is_rd && prio_hit),
    .addr  (bidx[PAW-1:0]),
    .wdata (bus_wdata),
    .rdata (prio_q)
  );

  // Read path
  logic [31:0] rd_next, rd_q;
  logic        sel_prio_q;

  always_comb begin
    rd_next = '0;
    unique case (region)
      RG_MISC: begin
        if (ctl_hit)       rd_next = {31'd0, gen_q};
        else if (type_hit) rd_next = TYPE_VAL;
        else if (ens_hit || enc_hit || pcl_hit) begin
          if (widx == 5'd0) begin
            if (core_ok) rd_next = pcl_hit ? bank_pd[bus_core] : bank_en[bus_core];
          end else begin
            for (int w = 1; w < NW32; w++)
              if (int'(widx) == w)
                rd_next = pcl_hit ? pd_sh[(w-1)*32 +: 32] : en_sh[(w-1)*32 +: 32];
          end
        end
      end
      RG_TGT: begin
        if (int'(bidx) < 8) begin
          if (core_ok) rd_next = 32'h0101_0101 << bus_core;
        end else begin
          for (int j = 0; j < NS; j++)
            if (int'(bidx) == (j + 32) / 4) rd_next[8*(j%4) +: 8] = tgt_sh[j];
        end
      end
      RG_CFG:  if (int'(bidx) < NW16) rd_next = cfg_q[bidx[CFW-1:0]];
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q       <= '0;
      sel_prio_q <= 1'b0;
    end else begin
      rd_q       <= is_rd ? rd_next : '0;
      sel_prio_q <= is_rd && prio_hit;
    end
  end

  assign rd_data = sel_prio_q ? prio_q : rd_q;

  // Forwarding
  irq_dist_route #(.NUM_CORES(NUM_CORES), .NUM_IRQ(NUM_IRQ)) u_route (
    .clk      (clk),
    .rst      (rst),
    .gen      (gen_q),
    .priv_en  (priv_en_f),
    .priv_pd  (priv_pd_f),
    .sh_en    (en_sh),
    .sh_pd    (pd_sh),
    .sh_tgt   (tgt_flat),
    .core_irq (core_irq)
  );
endmodule

// File: rtl/irq_dist_checker.sv
`timescale 1ns/1ps
module irq_dist_checker #(
  parameter int NUM_CORES = 2,
  parameter int NUM_IRQ   = 64
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_req,
  input logic                 bus_wr,
  input logic [9:0]           bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          rd_data,
  input logic [NUM_CORES-1:0] core_irq,
  input logic                 gen_q,
  input logic [NUM_IRQ-33:0]  en_sh
);
  localparam logic [31:0] TYPE_VAL =
    32'((NUM_IRQ / 32 - 1) & 31) | (32'((NUM_CORES - 1) & 7) << 5);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (core_irq == '0 && rd_data == '0));

  assert_switch_off_R9: assert property (@(posedge clk) disable iff (rst)
    !gen_q |=> core_irq == '0);

  assert_type_value_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_wr && bus_addr == 10'h001) |=> rd_data == TYPE_VAL);

  assert_idle_read_zero_R14: assert property (@(posedge clk) disable iff (rst)
    (!bus_req || bus_wr) |=> rd_data == '0);

  assert_enable_set_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_wr && bus_addr == 10'h041)
      |=> (en_sh[31:0] & $past(bus_wdata)) == $past(bus_wdata));
endmodule

bind irq_dist_regs irq_dist_checker #(.NUM_CORES(NUM_CORES), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_data   (rd_data),
  .core_irq  (core_irq),
  .gen_q     (gen_q),
  .en_sh     (en_sh[31:0])
);

// File: tb/tb_irq_dist_regs.sv
`timescale 1ns/1ps
module tb_irq_dist_regs;
  localparam int NC = 2;
  localparam int NI = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [0:0]  bus_core = '0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data;
  logic [NI-33:0] spi_in = '0;
  logic [NC*16-1:0] ppi_in = '0;
  logic [NC-1:0] core_irq;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_dist_regs #(.NUM_CORES(NC), .NUM_IRQ(NI)) dut (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_core(bus_core), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .spi_in(spi_in), .ppi_in(ppi_in), .core_irq(core_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int core, input int addr, input logic [31:0] data);
    bus_req = 1'b1; bus_wr = 1'b1; bus_core = 1'(core);
    bus_addr = 10'(addr); bus_wdata = data;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input int core, input int addr, output logic [31:0] data);
    bus_req = 1'b1; bus_wr = 1'b0; bus_core = 1'(core); bus_addr = 10'(addr);
    @(negedge clk);
    bus_req = 1'b0;
    data = rd_data;
  endtask

  function automatic logic [31:0] pat(input int w);
    return (32'h1357_9BDF * 32'(w + 3)) ^ 32'hA5A5_0000;
  endfunction

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 core_irq", 32'(core_irq), 0);
    rd(0, 'h000, d); check("R1 ctrl", d, 0);
    rd(0, 'h041, d); check("R1 enables", d, 0);
    rd(1, 'h0A1, d); check("R1 pending", d, 0);
    check("R14 idle read", rd_data, 0);

    // R7 type register, read-only
    rd(0, 'h001, d); check("R7 type", d, 32'h21);
    wr(0, 'h001, 32'hFFFF_FFFF);
    rd(1, 'h001, d); check("R7 type after write", d, 32'h21);

    // R2/R3 enable set sweep over shared IDs, one bit at a time
    for (int n = 32; n < 64; n++) begin
      wr(0, 'h040 + n/32, 32'd1 << (n % 32));
      rd(0, 'h040 + n/32, d);
      check("R3 enable set sweep", d, 32'((64'd1 << (n % 32 + 1)) - 1));
    end
    wr(0, 'h061, 32'h5555_5555);
    rd(1, 'h061, d); check("R2 enable clear", d, 32'hAAAA_AAAA);
    wr(0, 'h041, 32'h0); wr(0, 'h061, 32'h0);
    rd(0, 'h041, d); check("R2 zero write no effect", d, 32'hAAAA_AAAA);
    wr(0, 'h061, 32'hFFFF_FFFF);
    rd(0, 'h041, d); check("R2 clear all", d, 0);

    // R4 priority sweep
    for (int w = 0; w < 16; w++) wr(w % 2, 'h100 + w, pat(w));
    for (int w = 0; w < 16; w++) begin
      rd(0, 'h100 + w, d); check("R4 priority readback", d, pat(w));
    end
    rd(0, 'h110, d); check("R11 priority beyond range", d, 0);

    // R5 routing masks
    for (int w = 8; w < 16; w++) wr(0, 'h200 + w, pat(w + 20));
    for (int w = 8; w < 16; w++) begin
      rd(1, 'h200 + w, d); check("R5 routing readback", d, pat(w + 20));
    end
    wr(0, 'h203, 32'hFFFF_FFFF);
    rd(0, 'h203, d); check("R5 private routing core0", d, 32'h0101_0101);
    rd(1, 'h207, d); check("R5 private routing core1", d, 32'h0202_0202);
    wr(0, 'h210, 32'hFFFF_FFFF);
    rd(0, 'h210, d); check("R11 routing beyond range", d, 0);

    // R6 trigger words
    for (int w = 0; w < 4; w++) wr(0, 'h300 + w, pat(w + 40));
    for (int w = 0; w < 4; w++) begin
      rd(0, 'h300 + w, d); check("R6 trigger readback", d, pat(w + 40));
    end
    wr(0, 'h304, 32'hFFFF_FFFF);
    rd(0, 'h304, d); check("R11 trigger beyond range", d, 0);
    for (int w = 0; w < 4; w++) wr(0, 'h300 + w, 32'h0);

    // R11 enable beyond range, unmapped
    wr(0, 'h042, 32'hFFFF_FFFF);
    rd(0, 'h042, d); check("R11 enable word 2", d, 0);
    rd(0, 'h0E0, d); check("R11 unmapped", d, 0);

    // R8 banking
    wr(0, 'h040, 32'hFFFF_0000);
    rd(1, 'h040, d); check("R8 other core copy", d, 0);
    rd(0, 'h060, d); check("R8 own core copy", d, 32'hFFFF_0000);
    wr(0, 'h060, 32'hFFFF_FFFF);

    // R9/R12 routing of shared ID 40 (line 8) to core 1, ID 41 (line 9) to core 0
    for (int w = 8; w < 16; w++) wr(0, 'h200 + w, 32'h0);
    wr(0, 'h20A, 32'h0000_0102);
    wr(0, 'h041, 32'h0000_0100);
    spi_in[8] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 switch off blocks", 32'(core_irq), 0);
    wr(0, 'h000, 32'h1);
    @(negedge clk);
    check("R12 forward ID40 to core1", 32'(core_irq), 32'b10);
    // R13 clear while level line high: comes back
    wr(0, 'h0A1, 32'h0000_0100);
    @(negedge clk);
    check("R13 level reasserts", 32'(core_irq), 32'b10);
    spi_in[8] = 1'b0;
    @(negedge clk);
    wr(0, 'h0A1, 32'h0000_0100);
    @(negedge clk);
    check("R13 clear after line low", 32'(core_irq), 0);
    wr(0, 'h061, 32'h0000_0100);

    // R6 edge-triggered ID 41: trigger word 2, bit 19
    wr(0, 'h302, 32'h0008_0000);
    wr(0, 'h041, 32'h0000_0200);
    spi_in[9] = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R6 edge sets pending", 32'(core_irq), 32'b01);
    wr(0, 'h0A1, 32'h0000_0200);
    @(negedge clk);
    check("R6 edge stays cleared", 32'(core_irq), 0);
    rd(0, 'h0A1, d); check("R13 pending read", d, 0);
    spi_in[9] = 1'b0;
    wr(0, 'h061, 32'h0000_0200);

    // R10 software trigger of private ID 3
    wr(0, 'h040, 32'h8); wr(1, 'h040, 32'h8);
    wr(0, 'h0C0, 32'h0001_0003);
    @(negedge clk);
    check("R10 trigger core0", 32'(core_irq), 32'b01);
    wr(1, 'h0C0, 32'h0002_0003);
    @(negedge clk);
    check("R10 trigger core1", 32'(core_irq), 32'b11);
    wr(0, 'h0A0, 32'h8);
    @(negedge clk);
    check("R8 banked pending clear", 32'(core_irq), 32'b10);
    rd(1, 'h0A0, d); check("R8 core1 pending kept", d, 32'h8);
    rd(0, 'h0A0, d); check("R8 core0 pending gone", d, 0);

    // private level line: core1 ID 18
    ppi_in[16 + 2] = 1'b1;
    @(negedge clk); @(negedge clk);
    rd(1, 'h0A0, d); check("R12 private line pending", d, 32'h0004_0008);
    rd(0, 'h0A0, d); check("R8 private line other core", d, 0);

    // R9 switch off
    wr(0, 'h000, 32'h0);
    @(negedge clk);
    check("R9 switch off clears", 32'(core_irq), 0);

    summary();
    $finish;
  end
endmodule